// File: doc/BRIEF.md
# Serial-Bus Slave with Register Pointer

This block is a two-wire serial-bus slave that sits on a system clock and watches the bus clock and data lines as ordinary inputs. It pulls the data line low through a single open-drain enable. Inside it holds a small file of byte-wide registers. All access to that file goes through one byte-wide pointer register.

A write transaction carries the slave address with the direction bit clear. Its first byte always lands in the pointer. An optional second byte is stored in the register the pointer selects. A read transaction carries the direction bit set and returns one byte from the register at the pointer. The pointer is never advanced automatically. A pointer-only write followed by any number of reads therefore keeps fetching the same register.

The low bits of the 7-bit slave address come from a strap input. The strap is captured once after reset, so several copies of the block can share one bus.

Top module: `smb_ptr_slave`

## Requirements
- R1: Every byte takes nine bus-clock pulses: eight data bits, most significant bit first, then an acknowledge bit. A receiver acknowledges by holding data low while the ninth clock is high.
- R2: The slave changes its data-line drive only while the bus clock is low.
- R3: A data fall while the clock is high starts a transaction, and a data rise while the clock is high stops it. After a stop, and during the master's ninth bit of a read, the slave leaves data released.
- R4: The first byte after a start is the 7-bit address followed by the direction bit (0 write, 1 read). The slave acknowledges only the address {BASE_ADDR[6:SEL_W], strap}, which is 7'h2D for the defaults with strap 2'b01. On any other address it gives no acknowledge and leaves data released until the next start, and the pointer and registers stay unchanged.
- R5: In a write, the first byte after the address is acknowledged and loaded into the pointer.
- R6: A second write byte is acknowledged and stored in the register selected by the pointer. When the pointer is NUM_REGS or more, that byte is acknowledged but stored nowhere.
- R7: A write that carries only the pointer byte and then stops changes the pointer and leaves every register unchanged.
- R8: A read returns the register at the pointer, or 8'h00 when the pointer is out of range. A read leaves the pointer unchanged, so repeated reads return the same register.
- R9: A read returns exactly one byte. If the master acknowledges it and clocks further bytes, the slave keeps data released, so those bytes read as 8'hFF.
- R10: Write bytes after the second are not acknowledged and change nothing.
- R11: A repeated start begins a fresh transaction with a new direction and keeps the current pointer.
- R12: The strap is sampled on the first clock after reset is released. Later changes to it have no effect until the next reset.
- R13: Reset clears the pointer to 0, releases data, and loads register i with 8'hA0 + i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| addrSel | input | SEL_W | Strap for the low address bits |
| sdaOe | output | 1 | Pull data low when 1 |

## Verification
The assertions check several things on every cycle:
- the data drive holds still while the bus clock is high;
- a stop releases the line;
- a rejected address or a finished read byte leaves the line released;
- the third and later write bytes are never acknowledged;
- only one of pointer load, register write and read load fires in a cycle;
- registers and pointer move only on their own strobes.

Some behaviour only the bench scenarios can show. These are the values that come back from the register file, and the way a pointer-only write steers a later read. They also include a repeated start keeping the pointer, and out-of-range pointers reading zero while writing nowhere. The last is that the strap is latched at reset and ignored afterwards.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic ackDrive;
    logic txDrive;
  } dpCtl_t;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA, K_EXTRA} rxKind_t;
  typedef enum logic [1:0] {S_IDLE, S_RX, S_TX, S_DONE} phase_t;

endpackage

// File: rtl/smb_ptr_ctrl.sv
module smb_ptr_ctrl
  import smb_ptr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   addrMatch,
  input  logic   rwBit,
  output dpCtl_t ctl
);

  logic    sclQ, sdaQ;
  phase_t  state;
  rxKind_t kind;
  logic [3:0] bitCnt;
  logic    ackDrive, txDrive, isRead;

  logic sclRise, sclFall, startDet, stopDet;
  logic byteEnd, ackEnd;

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;

  assign byteEnd = (state == S_RX) && sclFall && (bitCnt == 4'd8);
  assign ackEnd  = (state == S_RX) && sclFall && (bitCnt == 4'd9);

  always_comb begin
    ctl          = '0;
    ctl.shiftIn  = (state == S_RX) && sclRise && (bitCnt < 4'd8);
    ctl.loadPtr  = byteEnd && (kind == K_PTR);
    ctl.writeReg = byteEnd && (kind == K_DATA);
    ctl.loadTx   = ackEnd && (kind == K_ADDR) && isRead;
    ctl.shiftTx  = (state == S_TX) && sclFall && (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    ctl.ackDrive = ackDrive;
    ctl.txDrive  = txDrive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      state    <= S_IDLE;
      kind     <= K_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
      isRead   <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startDet) begin
        state    <= S_RX;
        kind     <= K_ADDR;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
      end else if (stopDet) begin
        state    <= S_IDLE;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise && bitCnt != 4'd9) bitCnt <= bitCnt + 4'd1;
            if (byteEnd) begin
              if (kind == K_ADDR && !addrMatch) begin
                state <= S_DONE;
              end else begin
                ackDrive <= (kind != K_EXTRA);
                if (kind == K_ADDR) isRead <= rwBit;
              end
            end
            if (ackEnd) begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              if (kind == K_ADDR && isRead) begin
                state   <= S_TX;
                txDrive <= 1'b1;
              end else begin
                case (kind)
                  K_ADDR:  kind <= K_PTR;
                  K_PTR:   kind <= K_DATA;
                  default: kind <= K_EXTRA;
                endcase
              end
            end
          end
          S_TX: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (sclFall && bitCnt == 4'd8) begin
              txDrive <= 1'b0;
              state   <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!ackDrive && !txDrive)); // R3

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |-> (!ackDrive && !txDrive)); // R4

  AST_NO_EXTRA_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX && kind == K_EXTRA) |-> !ackDrive); // R10

endmodule

// File: rtl/smb_ptr_dp.sv
module smb_ptr_dp
  import smb_ptr_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter logic [6:0] BASE_ADDR = 7'h2C,
  parameter int         SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] addrSel,
  input  dpCtl_t           ctl,
  output logic             addrMatch,
  output logic             rwBit,
  output logic             sdaOe
);

  localparam int         PTR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NUM_REGS_B = 8'(NUM_REGS);

  logic [7:0]                rxByte;
  logic [7:0]                txShift;
  logic [7:0]                ptr;
  logic [NUM_REGS-1:0][7:0]  regs;
  logic [SEL_W-1:0]          selQ;
  logic                      selTaken;
  logic [7:0]                readVal;

  assign addrMatch = (rxByte[7:1] == {BASE_ADDR[6:SEL_W], selQ});
  assign rwBit     = rxByte[0];
  assign readVal   = (ptr < NUM_REGS_B) ? regs[ptr[PTR_W-1:0]] : 8'h00;
  assign sdaOe     = ctl.ackDrive | (ctl.txDrive & ~txShift[7]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= '0;
      selTaken <= 1'b0;
    end else if (!selTaken) begin
      selQ     <= addrSel;
      selTaken <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= 8'hFF;
      ptr     <= '0;
    end else begin
      if (ctl.shiftIn) rxByte <= {rxByte[6:0], sdaIn};
      if (ctl.loadPtr) ptr <= rxByte;
      if (ctl.loadTx)       txShift <= readVal;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN)                              regs[i] <= 8'hA0 + 8'(i);
      else if (ctl.writeReg && ptr == 8'(i))  regs[i] <= rxByte;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadPtr, ctl.writeReg, ctl.loadTx})); // R5

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.writeReg |=> $stable(regs)); // R7

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadPtr |=> $stable(ptr)); // R11

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_ptr_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter logic [6:0] BASE_ADDR = 7'h2C,
  parameter int         SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] addrSel,
  output logic             sdaOe
);

  dpCtl_t ctl;
  logic   addrMatch, rwBit;

  smb_ptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .ctl(ctl)
  );

  smb_ptr_dp #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .addrSel(addrSel), .ctl(ctl),
    .addrMatch(addrMatch), .rwBit(rwBit), .sdaOe(sdaOe)
  );

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe)); // R2

endmodule

// File: tb/smb_ptr_slave_test.sv
module smb_ptr_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;
  localparam logic [6:0] ADDR_A   = 7'h2D;
  localparam logic [6:0] ADDR_B   = 7'h2E;
  localparam logic [6:0] ADDR_BAD = 7'h2C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic [1:0] addrSel = 2'b01;
  logic sdaOe;
  logic busSda;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int expRegs[8];
  int expPtr;

  assign busSda = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_ptr_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(busSda),
    .addrSel(addrSel), .sdaOe(sdaOe)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic sclPrev = 1'b0;
  logic oePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && scl && sclPrev) begin
      vectors++;
      if (sdaOe != oePrev) begin
        miscompares++;
        $display("FAIL R2: drive changed with clock high, actual %0b expected %0b", sdaOe, oePrev);
      end
    end
    sclPrev = scl;
    oePrev = sdaOe;
  end

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] sel);
    rstN = 1'b0; addrSel = sel; scl = 1'b1; mSda = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    for (int i = 0; i < 8; i++) expRegs[i] = 'hA0 + i;
    expPtr = 0;
  endtask

  task automatic startCond();
    mSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      scl = 1'b1; waitQ(); waitQ();
      scl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    ack = ~busSda;
    waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] b, output logic oe9);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      scl = 1'b1; waitQ();
      b[i] = busSda;
      waitQ();
      scl = 1'b0; waitQ();
    end
    mSda = ~mAck; waitQ();
    scl = 1'b1; waitQ();
    oe9 = sdaOe;
    waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic readTxn(input logic [6:0] a, input string tag, input int exp);
    bit ack; logic [7:0] b; logic oe9;
    startCond();
    sendByte({a, 1'b1}, ack);
    check({tag, " read address ack"}, int'(ack), 1);
    readByte(1'b0, b, oe9);
    check(tag, int'(b), exp);
    check("R3 released during master NACK", int'(oe9), 0);
    stopCond();
  endtask

  task automatic writeTxn(input logic [6:0] a, input int nBytes, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2, input string tag);
    bit ack;
    startCond();
    sendByte({a, 1'b0}, ack);
    check({tag, " write address ack"}, int'(ack), 1);
    sendByte(b0, ack);
    check("R5 pointer byte ack", int'(ack), 1);
    expPtr = b0;
    if (nBytes > 1) begin
      sendByte(b1, ack);
      check("R6 data byte ack", int'(ack), 1);
      if (expPtr < 8) expRegs[expPtr] = b1;
    end
    if (nBytes > 2) begin
      sendByte(b2, ack);
      check("R10 third byte not acked", int'(ack), 0);
    end
    stopCond();
  endtask

  initial begin
    bit ack; logic [7:0] b; logic oe9;
    doReset(2'b01);
    check("R13 released after reset", int'(sdaOe), 0);
    readTxn(ADDR_A, "R13 reset pointer reads reg0", expRegs[0]);

    startCond();
    sendByte({ADDR_BAD, 1'b0}, ack);
    check("R4 wrong address not acked", int'(ack), 0);
    sendByte(8'h03, ack);
    check("R4 byte after wrong address not acked", int'(ack), 0);
    stopCond();
    readTxn(ADDR_A, "R4 pointer unchanged by foreign frame", expRegs[0]);

    writeTxn(ADDR_A, 2, 8'h02, 8'h5A, 8'h00, "R4");
    readTxn(ADDR_A, "R1 R8 read back written register", expRegs[2]);

    writeTxn(ADDR_A, 1, 8'h05, 8'h00, 8'h00, "R7");
    readTxn(ADDR_A, "R7 pointer-only write then read", expRegs[5]);
    readTxn(ADDR_A, "R8 repeat read without new pointer", expRegs[expPtr]);

    writeTxn(ADDR_A, 3, 8'h01, 8'h11, 8'h22, "R10");
    readTxn(ADDR_A, "R10 extra byte ignored", expRegs[1]);

    startCond();
    sendByte({ADDR_A, 1'b0}, ack);
    check("R11 write address ack", int'(ack), 1);
    sendByte(8'h03, ack);
    check("R11 pointer ack", int'(ack), 1);
    expPtr = 3;
    startCond();
    sendByte({ADDR_A, 1'b1}, ack);
    check("R11 read address after repeated start", int'(ack), 1);
    readByte(1'b0, b, oe9);
    check("R11 read after repeated start", int'(b), expRegs[3]);
    startCond();
    sendByte({ADDR_A, 1'b1}, ack);
    readByte(1'b0, b, oe9);
    check("R11 pointer kept across repeated start", int'(b), expRegs[3]);
    stopCond();

    startCond();
    sendByte({ADDR_A, 1'b1}, ack);
    readByte(1'b1, b, oe9);
    check("R9 first byte", int'(b), expRegs[3]);
    readByte(1'b0, b, oe9);
    check("R9 second byte released", int'(b), 'hFF);
    stopCond();

    writeTxn(ADDR_A, 2, 8'h09, 8'h77, 8'h00, "R6");
    readTxn(ADDR_A, "R8 out-of-range pointer reads zero", 0);
    writeTxn(ADDR_A, 1, 8'h01, 8'h00, 8'h00, "R6");
    readTxn(ADDR_A, "R6 out-of-range write stored nowhere", expRegs[1]);

    addrSel = 2'b10;
    waitQ();
    readTxn(ADDR_A, "R12 old address still active", expRegs[1]);
    startCond();
    sendByte({ADDR_B, 1'b1}, ack);
    check("R12 new strap ignored before reset", int'(ack), 0);
    stopCond();

    doReset(2'b10);
    readTxn(ADDR_B, "R12 R13 new strap after reset", expRegs[0]);
    startCond();
    sendByte({ADDR_A, 1'b1}, ack);
    check("R12 old address rejected after reset", int'(ack), 0);
    stopCond();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule